// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block sits between a host register port and a small word-addressed configuration store of 64 words of 16 bits. The host sees two 16-bit registers: a command register and a data register. The host places an opcode and a word address into the command register, then polls bit 15 of the same register until it reads zero. A read leaves the addressed word in the data register. An erase or a write changes the storage array, but only while a write-enable latch is set. Each operation holds the busy flag for a fixed number of clock cycles, set by a parameter, so the controller's timing is fixed and known.

A word update takes five steps, and the host waits for busy to clear between them: set the latch, erase the word, load the data register, set the latch again, then write. Any checksum over the contents is computed by host software. The first three words also drive a 48-bit station address output, so the host can program the node address through the same path.

Top module: `nvword_ctrl`

## Requirements
- R1: After reset, busy is 0, both registers read 0 and every storage word holds 0xFFFF. The command register reads back busy on bit 15, and on bits 14:0 the bits 14:0 of the last command word accepted.
- R2: A command word is decoded with the opcode in bits 7:6 and the word address in bits 5:0. Opcode 2 is read, 3 is erase, 1 is write and 0 is control.
- R3: A read holds busy for exactly READ_LAT cycles. When busy clears, the data register holds the addressed word.
- R4: An erase with the latch set holds busy for exactly PROG_LAT cycles. When busy clears, the addressed word is 0xFFFF.
- R5: A write with the latch set holds busy for exactly PROG_LAT cycles. When busy clears, the addressed word equals the data register.
- R6: The control command 0x30 sets the write-enable latch at once, with no busy time. An erase or a write issued while the latch is clear is ignored: busy stays 0 and the array does not change.
- R7: The latch clears when an erase or a write completes. The control command 0x00 also clears it. Any other control sub-code has no effect on the latch.
- R8: A command written while busy is 1 is discarded. It does not change the command readback and does not start an operation.
- R9: A data register write made while busy is 1 is discarded.
- R10: The station address output carries words 0, 1 and 2, high byte first. Byte 0 sits in bits 47:40 and is the high byte of word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Register select: 0 = command, 1 = data |
| reg_wdata | input | 16 | Write data |
| cmd_rdata | output | 16 | Command register readback: busy on bit 15 |
| data_rdata | output | 16 | Data register readback |
| station_addr | output | 48 | Station address taken from words 0 to 2 |

## Verification
A command strobe is captured on one rising edge, and busy reads 1 after that edge. A read or a program operation then lasts READ_LAT or PROG_LAT edges. The read data, the array update and the latch clear all become visible on the same edge at which busy falls. Latch control and ignored commands take effect, or show that they took none, straight after the capture edge. The bench drives and samples on falling edges and counts the falling edges at which busy is high after the capture edge, so the count must equal the latency exactly. It reads results only once busy has dropped, and checks ignored commands on the very next sample.

// File: rtl/nvword_ctrl.sv
module nvword_ctrl #(
  parameter int WORDS    = 64,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int READ_LAT = 4,
  parameter int PROG_LAT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   cmd_rdata,
  output logic [15:0]   data_rdata,
  output logic [47:0]   station_addr
);
  localparam int LAT_MAX = (READ_LAT > PROG_LAT) ? READ_LAT : PROG_LAT;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam logic [1:0] OP_CTL = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_ER = 2'd3;
  localparam logic [ADDR_W-1:0] SUB_WEN = ADDR_W'(6'h30), SUB_WDIS = '0;

  logic [DATA_W-1:0] mem [WORDS];
  logic              busy, wel;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [14:0]       last_cmd;
  logic [DATA_W-1:0] data_q;

  wire [1:0]        op_in   = reg_wdata[ADDR_W+1:ADDR_W];
  wire [ADDR_W-1:0] addr_in = reg_wdata[ADDR_W-1:0];
  wire cmd_acc  = reg_wr && !reg_sel && !busy;
  wire data_acc = reg_wr &&  reg_sel && !busy;
  wire start_rd = cmd_acc && op_in == OP_RD;
  wire start_pg = cmd_acc && (op_in == OP_WR || op_in == OP_ER) && wel;
  wire done     = busy && cnt == '0;

  assign cmd_rdata    = {busy, last_cmd};
  assign data_rdata   = data_q;
  assign station_addr = {mem[0], mem[1], mem[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wel      <= 1'b0;
      cnt      <= '0;
      cur_op   <= OP_CTL;
      cur_addr <= '0;
      last_cmd <= '0;
      data_q   <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      if (cmd_acc) begin
        last_cmd <= reg_wdata[14:0];
        cur_op   <= op_in;
        cur_addr <= addr_in;
        if (op_in == OP_CTL && addr_in == SUB_WEN)  wel <= 1'b1;
        if (op_in == OP_CTL && addr_in == SUB_WDIS) wel <= 1'b0;
      end
      if (data_acc) data_q <= reg_wdata;
      if (start_rd) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(READ_LAT - 1);
      end else if (start_pg) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(PROG_LAT - 1);
      end else if (done) begin
        busy <= 1'b0;
        case (cur_op)
          OP_RD: data_q <= mem[cur_addr];
          OP_ER: begin mem[cur_addr] <= '1;     wel <= 1'b0; end
          OP_WR: begin mem[cur_addr] <= data_q; wel <= 1'b0; end
          default: ;
        endcase
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

module nvword_ctrl_chk #(
  parameter int READ_LAT = 4,
  parameter int PROG_LAT = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [15:0] reg_wdata,
  input logic [15:0] cmd_rdata,
  input logic [15:0] data_rdata,
  input logic        wel
);
  wire       busy = cmd_rdata[15];
  wire [1:0] op   = cmd_rdata[7:6];
  int busy_cyc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_cyc <= 0;
    else if (busy) busy_cyc <= busy_cyc + 1;
    else busy_cyc <= 0;

  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && op == 2'd2) |-> busy_cyc == READ_LAT);
  a_r4_r5_prog_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && op != 2'd2) |-> busy_cyc == PROG_LAT);
  a_r6_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && !reg_sel && !wel && (reg_wdata[7:6] == 2'd1 || reg_wdata[7:6] == 2'd3)) |=> !busy);
  a_r7_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && op != 2'd2) |-> !wel);
  a_r8_cmd_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && !reg_sel) |=> $stable(cmd_rdata[14:0]));
  a_r9_data_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op != 2'd2) |=> $stable(data_rdata));
  a_r2_busy_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && !reg_sel));
endmodule

bind nvword_ctrl nvword_ctrl_chk #(.READ_LAT(READ_LAT), .PROG_LAT(PROG_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .cmd_rdata(cmd_rdata), .data_rdata(data_rdata), .wel(wel));

// File: tb/nvword_ctrl_tb.sv
module nvword_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int RL = 4;
  localparam int PL = 12;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] cmd_rdata, data_rdata;
  logic [47:0] station_addr;
  int checks = 0, fails = 0;
  logic [15:0] model [64];

  nvword_ctrl #(.READ_LAT(RL), .PROG_LAT(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_rdata(cmd_rdata), .data_rdata(data_rdata), .station_addr(station_addr));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic sel, input logic [15:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (cmd_rdata[15]) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input logic [5:0] a, input string req);
    int n;
    put(1'b0, {8'h00, 2'd2, a});
    wait_idle(n);
    chk({req, " read latency (R3)"}, n, RL);
    chk({req, " read data (R3)"}, data_rdata, model[a]);
  endtask

  task automatic prog(input logic [1:0] op, input logic [5:0] a, input string req);
    int n;
    put(1'b0, {8'h00, op, a});
    wait_idle(n);
    chk({req, " program latency (R4/R5)"}, n, PL);
  endtask

  task automatic update(input logic [5:0] a, input logic [15:0] v);
    put(1'b0, 16'h0030);
    prog(2'd3, a, "erase R4");
    model[a] = 16'hFFFF;
    rd(a, "erased R4");
    put(1'b1, v);
    put(1'b0, 16'h0030);
    prog(2'd1, a, "write R5");
    model[a] = v;
  endtask

  task automatic t_reset;
    chk("R1 busy/cmd after reset", cmd_rdata, 16'h0000);
    chk("R1 data after reset", data_rdata, 16'h0000);
    chk("R1 array erased", station_addr, 48'hFFFF_FFFF_FFFF);
    rd(6'd9, "R1 R2 erased word");
  endtask

  task automatic t_locked;
    put(1'b1, 16'h1234);
    put(1'b0, {8'h00, 2'd1, 6'd5});
    chk("R6 locked write no busy", cmd_rdata[15], 1'b0);
    put(1'b0, {8'h00, 2'd3, 6'd5});
    chk("R6 locked erase no busy", cmd_rdata[15], 1'b0);
    rd(6'd5, "R6 locked array");
  endtask

  task automatic t_update;
    update(6'd5, 16'hBEEF);
    rd(6'd5, "R5 written word");
    chk("R1 cmd readback", cmd_rdata[14:0], 15'h0085);
    update(6'd63, 16'h0F0F);
    rd(6'd63, "R2 top address");
    rd(6'd5, "R5 neighbour intact");
  endtask

  task automatic t_latch_clear;
    put(1'b1, 16'h5555);
    put(1'b0, {8'h00, 2'd1, 6'd5});
    chk("R7 latch cleared after write", cmd_rdata[15], 1'b0);
    put(1'b0, 16'h0030);
    put(1'b0, 16'h0000);
    put(1'b0, {8'h00, 2'd3, 6'd5});
    chk("R7 disable clears latch", cmd_rdata[15], 1'b0);
    put(1'b0, 16'h0010);
    put(1'b0, {8'h00, 2'd3, 6'd5});
    chk("R7 other sub-code no effect", cmd_rdata[15], 1'b0);
    rd(6'd5, "R7 array unchanged");
  endtask

  task automatic t_busy_discard;
    int n;
    put(1'b0, {8'h00, 2'd2, 6'd5});
    put(1'b0, {8'h00, 2'd2, 6'd63});
    chk("R8 cmd readback kept", cmd_rdata[14:0], 15'h0085);
    wait_idle(n);
    chk("R8 first read result", data_rdata, model[5]);
    put(1'b1, 16'hAAAA);
    put(1'b0, 16'h0030);
    put(1'b0, {8'h00, 2'd1, 6'd7});
    put(1'b1, 16'h7777);
    chk("R9 data write while busy", data_rdata, 16'hAAAA);
    wait_idle(n);
    model[7] = 16'hAAAA;
    rd(6'd7, "R9 stored value");
  endtask

  task automatic t_station;
    update(6'd0, 16'hA1B2);
    update(6'd1, 16'hC3D4);
    update(6'd2, 16'hE5F6);
    @(negedge clk);
    chk("R10 station address", station_addr, 48'hA1B2_C3D4_E5F6);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_update();
    t_latch_clear();
    t_busy_discard();
    t_station();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule